// File: doc/BRIEF.md
# Soft-Start Ramp Sequencer

This block controls the power-up of one regulated output channel. A rising edge on the channel enable starts the sequence. The block then holds the output stage off for a programmable wait. When the wait ends, it enables switching pulses and raises a digital voltage reference from zero toward a target code, one 50 mV code at a time. A programmable number of microsecond ticks passes between code steps. When the reference reaches the target, a done flag goes high.

A single 16-bit word carries both timing settings. The upper six bits give the wait in 250-tick units. The lower ten bits give the dwell per reference step, in ticks. The word and the target code are captured at the start of each sequence. The control loop, the DAC and the pulse generator sit outside this block. An external 1 µs strobe paces all timing.

Top module: `ss_ramp_seq`

## Requirements
- R1: While rst_ni is low, and after reset until a sequence starts, pulse_en_o, done_o and ref_o are all 0.
- R2: A sequence starts only on a rising edge of en_i. At that edge the block captures cfg_i and target_i. Changing them later has no effect until the next rising edge.
- R3: During the wait phase, pulse_en_o and ref_o stay 0. The wait lasts 250 × cfg_i[15:10] ticks. The first clock edge at which en_i is seen high is edge 1, and tick_i is high every cycle. Then pulse_en_o goes high after edge 250·d+2, where d is cfg_i[15:10].
- R4: In the ramp phase, ref_o starts at 0 and rises by exactly one code (50 mV) each time cfg_i[9:0] ticks have passed. So ref_o equals k after edge 250·d+2+r·k.
- R5: A value of 0 in cfg_i[9:0] is treated as a dwell of 1 tick.
- R6: ref_o never exceeds the captured target. The last step is clamped to the target.
- R7: done_o goes high one edge after ref_o equals the captured target. That is after edge 250·d+3+r·T, with r the effective dwell and T the target. A target of 0 gives done after edge 250·d+3. While en_i stays high, done_o and pulse_en_o stay high and no new sequence starts.
- R8: When en_i is low at a clock edge, the next cycle shows pulse_en_o=0, ref_o=0 and done_o=0. This holds whatever phase the sequence was in.
- R9: Timers advance only on cycles where tick_i is high. While en_i is high and tick_i is low, ref_o does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Channel enable; a rising edge starts a sequence |
| cfg_i | input | 16 | [15:10] wait in 250-tick units, [9:0] ticks per reference step |
| target_i | input | 8 | Target reference code, in 50 mV units |
| tick_i | input | 1 | 1 µs timing strobe, one cycle wide |
| pulse_en_o | output | 1 | Switching pulses allowed |
| ref_o | output | 8 | Reference code sent to the control loop |
| done_o | output | 1 | Reference has reached the target |

## Verification
The hardest case to reach is a configuration change that arrives after the start edge, while the sequence is still running. Only the edge-time capture stops that change from taking effect. The stimulus starts a slow sequence and rewrites both cfg_i and target_i one cycle later. It then checks that every cycle of the run still follows the timing computed from the original values. Two more cases are reached by timing stimulus against the computed schedule: a tick outage in the middle of the ramp, and an enable drop at a chosen reference code.

// File: rtl/ss_ramp_pkg.sv
package ss_ramp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_RAMP  = 2'd2,
    ST_DONE  = 2'd3
  } ss_state_e;
endpackage

// File: rtl/ss_tick_timer.sv
module ss_tick_timer #(
  parameter int CNT_W = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             tick_i,
  output logic             zero_o,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (clr_i)                    cnt_q <= '0;
    else if (load_i)                   cnt_q <= load_val_i;
    else if (tick_i && cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
  // final tick of the current interval
  assign last_o = tick_i && (cnt_q == CNT_W'(1));
endmodule

// File: rtl/ss_ref_stepper.sv
module ss_ref_stepper #(
  parameter int REF_W = 8,
  parameter int STEP  = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             step_i,
  input  logic [REF_W-1:0] tgt_i,
  output logic [REF_W-1:0] ref_o,
  output logic             at_tgt_o
);
  logic [REF_W-1:0] ref_q;
  logic [REF_W-1:0] gap;

  assign gap = tgt_i - ref_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ref_q <= '0;
    else if (clr_i)     ref_q <= '0;
    else if (step_i) begin
      if (gap <= REF_W'(STEP)) ref_q <= tgt_i;  // clamp on last step
      else                     ref_q <= ref_q + REF_W'(STEP);
    end
  end

  assign ref_o    = ref_q;
  assign at_tgt_o = (ref_q == tgt_i);
endmodule

// File: rtl/ss_ramp_seq.sv
module ss_ramp_seq
  import ss_ramp_pkg::*;
#(
  parameter int CFG_W      = 16,
  parameter int RISE_W     = 10,
  parameter int REF_W      = 8,
  parameter int TICKS_UNIT = 250,
  parameter int STEP       = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [CFG_W-1:0] cfg_i,
  input  logic [REF_W-1:0] target_i,
  input  logic             tick_i,
  output logic             pulse_en_o,
  output logic [REF_W-1:0] ref_o,
  output logic             done_o
);
  localparam int DLY_W   = CFG_W - RISE_W;
  localparam int DLY_MAX = ((1 << DLY_W) - 1) * TICKS_UNIT;
  localparam int MAX_CNT = (DLY_MAX > (1 << RISE_W)) ? DLY_MAX : (1 << RISE_W);
  localparam int CNT_W   = $clog2(MAX_CNT + 1);

  ss_state_e        state_q, state_d;
  logic             en_q;
  logic [DLY_W-1:0] dly_q;
  logic [RISE_W-1:0] rise_q;
  logic [REF_W-1:0] tgt_q;

  logic             start;
  logic             tmr_load, tmr_zero, tmr_last;
  logic [CNT_W-1:0] tmr_val;
  logic             ref_clr, ref_step, at_tgt;
  logic [RISE_W-1:0] rise_eff;

  assign start    = en_i && !en_q && (state_q == ST_IDLE);
  assign rise_eff = (cfg_i[RISE_W-1:0] == '0) ? RISE_W'(1) : cfg_i[RISE_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      en_q    <= 1'b0;
      dly_q   <= '0;
      rise_q  <= '0;
      tgt_q   <= '0;
    end else begin
      state_q <= state_d;
      en_q    <= en_i;
      if (start) begin
        dly_q  <= cfg_i[CFG_W-1:RISE_W];
        rise_q <= rise_eff;
        tgt_q  <= target_i;
      end
    end
  end

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    ref_clr  = 1'b0;
    ref_step = 1'b0;
    if (!en_i) begin
      state_d = ST_IDLE;
      ref_clr = 1'b1;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start) begin
          state_d  = ST_WAIT;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(cfg_i[CFG_W-1:RISE_W]) * CNT_W'(TICKS_UNIT);
        end
        ST_WAIT: if (tmr_zero) begin
          state_d  = ST_RAMP;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(rise_q);
          ref_clr  = 1'b1;
        end
        ST_RAMP: begin
          if (at_tgt) state_d = ST_DONE;
          else if (tmr_last) begin
            ref_step = 1'b1;
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(rise_q);
          end
        end
        ST_DONE: ;
        default: state_d = ST_IDLE;
      endcase
    end
  end

  ss_tick_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (!en_i),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .tick_i     (tick_i),
    .zero_o     (tmr_zero),
    .last_o     (tmr_last)
  );

  ss_ref_stepper #(.REF_W(REF_W), .STEP(STEP)) u_ref (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (ref_clr),
    .step_i   (ref_step),
    .tgt_i    (tgt_q),
    .ref_o    (ref_o),
    .at_tgt_o (at_tgt)
  );

  assign pulse_en_o = (state_q == ST_RAMP) || (state_q == ST_DONE);
  assign done_o     = (state_q == ST_DONE);

  // dly_q kept for observability of the captured word
  logic unused_dly;
  assign unused_dly = ^dly_q;
endmodule

module ss_ramp_seq_chk #(
  parameter int REF_W = 8,
  parameter int STEP  = 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic             tick_i,
  input logic             pulse_en_o,
  input logic [REF_W-1:0] ref_o,
  input logic             done_o,
  input logic [REF_W-1:0] tgt_q
);
  assert_idle_on_disable_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!pulse_en_o && !done_o && ref_o == '0));

  assert_ref_zero_in_wait_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pulse_en_o |-> (ref_o == '0));

  assert_single_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_o > $past(ref_o)) |-> ((ref_o - $past(ref_o)) <= REF_W'(STEP)));

  assert_no_overshoot_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_o <= tgt_q);

  assert_done_at_target_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (ref_o == tgt_q && pulse_en_o));

  assert_frozen_without_tick_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !tick_i) |=> $stable(ref_o));
endmodule

bind ss_ramp_seq ss_ramp_seq_chk #(.REF_W(REF_W), .STEP(STEP)) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .en_i       (en_i),
  .tick_i     (tick_i),
  .pulse_en_o (pulse_en_o),
  .ref_o      (ref_o),
  .done_o     (done_o),
  .tgt_q      (tgt_q)
);

// File: tb/ss_ramp_seq_tb_top.sv
module ss_ramp_seq_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       en_i = 1'b0;
  logic [15:0] cfg_i = '0;
  logic [7:0] target_i = '0;
  logic       tick_i = 1'b1;
  logic       pulse_en_o, done_o;
  logic [7:0] ref_o;

  int total = 0;
  int bad = 0;
  bit ended = 0;

  always #5 clk_i = ~clk_i;

  ss_ramp_seq dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .cfg_i(cfg_i),
    .target_i(target_i), .tick_i(tick_i),
    .pulse_en_o(pulse_en_o), .ref_o(ref_o), .done_o(done_o)
  );

  // {delay units, rise field, target}
  localparam int NV = 6;
  localparam logic [23:0] VEC [NV] = '{
    {6'd0,  10'd0,    8'd0},
    {6'd0,  10'd1,    8'd5},
    {6'd1,  10'd3,    8'd4},
    {6'd2,  10'd0,    8'd7},
    {6'd0,  10'd1023, 8'd2},
    {6'd63, 10'd2,    8'd3}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // full sequence with per-cycle schedule check; mutate rewrites inputs after start
  task automatic run_seq(input int d, input int r, input int t, input bit mutate);
    int re, np, nd, bp, br, bd, ar, er;
    re = (r == 0) ? 1 : r;
    np = 250 * d + 2;
    nd = 250 * d + 3 + re * t;
    bp = 0; br = 0; bd = 0; ar = 0; er = 0;
    @(negedge clk_i);
    cfg_i = {d[5:0], r[9:0]};
    target_i = t[7:0];
    en_i = 1'b1;
    for (int n = 1; n <= nd + 4; n++) begin
      int xr;
      @(negedge clk_i);
      if (mutate && n == 1) begin
        cfg_i = {6'd0, 10'd5};
        target_i = 8'd200;
      end
      xr = (n >= np) ? (((n - np) / re) < t ? (n - np) / re : t) : 0;
      if (pulse_en_o !== (n >= np)) bp++;
      if (ref_o !== xr[7:0]) begin
        if (br == 0) begin ar = ref_o; er = xr; end
        br++;
      end
      if (done_o !== (n >= nd)) bd++;
    end
    chk(bp == 0, mutate ? "R2 pulse timing" : "R3 pulse timing", bp, 0);
    chk(br == 0, (r == 0) ? "R5 ref ramp" : "R4 ref ramp", ar, er);
    chk(bd == 0, "R7 done timing", bd, 0);
    chk(ref_o == t[7:0], "R6 final ref", ref_o, t);
    en_i = 1'b0;
    @(negedge clk_i);
    chk(!pulse_en_o && !done_o && ref_o == 0, "R8 idle after drop",
        {pulse_en_o, done_o, ref_o}, 0);
  endtask

  initial begin
    #2000000;
    if (!ended) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1 reset
    en_i = 1'b1; cfg_i = 16'h0001; target_i = 8'd3;
    repeat (3) @(negedge clk_i);
    chk(!pulse_en_o && !done_o && ref_o == 0, "R1 during reset", {pulse_en_o, done_o, ref_o}, 0);
    en_i = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    chk(!pulse_en_o && !done_o && ref_o == 0, "R1 after reset", {pulse_en_o, done_o, ref_o}, 0);

    for (int i = 0; i < NV; i++)
      run_seq(int'(VEC[i][23:18]), int'(VEC[i][17:8]), int'(VEC[i][7:0]), 1'b0);

    // R2 mid-sequence input change ignored
    run_seq(1, 2, 3, 1'b1);

    // R7 done holds and no restart while en stays high
    @(negedge clk_i);
    cfg_i = {6'd0, 10'd1}; target_i = 8'd2; en_i = 1'b1;
    repeat (10) @(negedge clk_i);
    chk(done_o && ref_o == 2, "R7 done hold", {done_o, ref_o}, {1'b1, 8'd2});
    target_i = 8'd9;
    repeat (20) @(negedge clk_i);
    chk(done_o && pulse_en_o && ref_o == 2, "R7 no restart", ref_o, 2);
    en_i = 1'b0;
    @(negedge clk_i);

    // R9 tick freeze mid-ramp
    cfg_i = {6'd0, 10'd2}; target_i = 8'd6; en_i = 1'b1;
    repeat (6) @(negedge clk_i);  // after edge 6: ref = (6-2)/2 = 2
    tick_i = 1'b0;
    repeat (15) @(negedge clk_i);
    chk(ref_o == 2 && !done_o, "R9 frozen ref", ref_o, 2);
    tick_i = 1'b1;
    repeat (12) @(negedge clk_i);
    chk(ref_o == 6 && done_o, "R9 resumes to target", ref_o, 6);
    en_i = 1'b0;
    @(negedge clk_i);

    // R8 drop during wait phase
    cfg_i = {6'd1, 10'd1}; target_i = 8'd4; en_i = 1'b1;
    repeat (50) @(negedge clk_i);
    en_i = 1'b0;
    @(negedge clk_i);
    en_i = 1'b1;  // rise restarts a fresh wait
    repeat (200) @(negedge clk_i);
    chk(!pulse_en_o, "R8 wait restarted", pulse_en_o, 0);
    en_i = 1'b0;
    @(negedge clk_i);

    // R8 drop mid-ramp
    cfg_i = {6'd0, 10'd3}; target_i = 8'd10; en_i = 1'b1;
    repeat (8) @(negedge clk_i);  // ref = (8-2)/3 = 2
    chk(ref_o == 2, "R4 mid-ramp code", ref_o, 2);
    en_i = 1'b0;
    @(negedge clk_i);
    chk(!pulse_en_o && ref_o == 0 && !done_o, "R8 drop mid-ramp", ref_o, 0);

    ended = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule